// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This block is a multiply/divide engine that sits beside an integer pipeline and owns a HI/LO result register pair. An operation starts when the caller raises `i_start` with an operation code and two operands while the unit is idle. The unit then works one result bit per clock, on operand magnitudes, and applies any sign fix-up and accumulation on the final clock. The number of clocks depends on the operation and, for signed division, on the operand signs. The unit counts on its own clock and takes no stall input, so a long operation overlaps whatever the pipeline is doing meanwhile.

The full-width products, the accumulating forms and the divides land in HI/LO. HI/LO are always visible on `o_hi`/`o_lo` for move-from reads, and two write ports let the pipeline load them while the unit is idle. The short multiply form sends the low half of its product to a general-register result port and leaves HI/LO alone. `o_busy` tells the caller to hold a new request. `o_done` pulses for one clock when a result is committed.

The width `W` is a parameter (32 by default). Every latency below is stated in terms of `W`. An operation "takes N clocks" when `o_done` is high after the N-th rising edge that follows the edge that accepted it.

Top module: `iterative_mdu`

## Requirements
- R1: After reset `o_busy`, `o_done`, `o_hi`, `o_lo` and `o_gpr` are all zero.
- R2: Op code 0 (signed) and op code 1 (unsigned) multiply `i_a` by `i_b` and write the 2W-bit product to {HI,LO}, taking W clocks.
- R3: Op code 2 multiplies signed operands and places the low W bits of the product on `o_gpr` in the cycle `o_done` is high. It leaves HI and LO unchanged and takes W clocks.
- R4: Op codes 3 (signed) and 4 (unsigned) add the 2W-bit product to {HI,LO}. Op codes 5 (signed) and 6 (unsigned) subtract the product from {HI,LO}. Both wrap modulo 2^(2W) and take W+2 clocks.
- R5: Op code 9 divides unsigned operands, placing the quotient in LO and the remainder in HI, and takes W+1 clocks.
- R6: Op code 8 divides signed operands. The quotient is truncated toward zero and the remainder takes the dividend's sign. It takes W+2 clocks when the divisor is negative, W+3 clocks when the dividend is negative and the divisor is not, and W+1 clocks otherwise.
- R7: A divide by zero completes with the latency R5/R6 give for its operands. HI/LO then hold unspecified values.
- R8: A start is accepted only on an edge where `o_busy` is low. `o_busy` is high from that edge until the completion edge. At the completion edge `o_done` rises for exactly one cycle as `o_busy` falls. A request held high through a busy period is accepted at the first edge after completion.
- R9: When idle, `i_hi_we`/`i_lo_we` load `i_hi_wdata`/`i_lo_wdata` into HI/LO at the clock edge. While busy these writes are ignored.
- R10: A start carrying op code 7 or any code from 10 to 15 is ignored: `o_busy` stays low and HI/LO are unchanged.
- R11: `o_gpr` changes only at the completion of an op-code-2 operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| i_start | input | 1 | Request to begin an operation |
| i_op | input | 4 | Operation code (see R2–R6, R10) |
| i_a | input | W | First operand / dividend |
| i_b | input | W | Second operand / divisor |
| i_hi_we | input | 1 | Load HI from `i_hi_wdata` when idle |
| i_hi_wdata | input | W | Data for HI load |
| i_lo_we | input | 1 | Load LO from `i_lo_wdata` when idle |
| i_lo_wdata | input | W | Data for LO load |
| o_busy | output | 1 | Operation in progress; hold new requests |
| o_done | output | 1 | One-cycle completion pulse |
| o_gpr | output | W | Short-multiply result for the general register file |
| o_hi | output | W | Current HI register |
| o_lo | output | W | Current LO register |

## Verification
A slip in the step or cycle counters shows up at once as `o_done` arriving a cycle early or late, at most W+3 clocks after the start. The bench measures that latency for every operation. An error in the one-bit-per-clock engines or in the sign flags shows only in the committed HI/LO or `o_gpr` value at that same completion edge, and sign faults only with negative operands. For this reason the bench sweeps every operand pair of a 4-bit configuration through all nine operations. Accumulator corruption, such as an ignored-write leak while busy, only becomes visible at the next read of HI/LO. The bench therefore preloads HI/LO before each operation and compares them after it.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    typedef enum logic [3:0] {
        OP_MULT  = 4'h0,
        OP_MULTU = 4'h1,
        OP_MUL   = 4'h2,
        OP_MADD  = 4'h3,
        OP_MADDU = 4'h4,
        OP_MSUB  = 4'h5,
        OP_MSUBU = 4'h6,
        OP_DIV   = 4'h8,
        OP_DIVU  = 4'h9
    } mdu_op_e;

    // Flags captured at issue and used at the commit edge
    typedef struct packed {
        mdu_op_e op;
        logic    neg_main;  // product / quotient must be negated
        logic    neg_rem;   // remainder must be negated
    } mdu_job_t;

    function automatic logic op_legal(input logic [3:0] code);
        case (code)
            4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h8, 4'h9: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic op_signed(input mdu_op_e op);
        return (op == OP_MULT) || (op == OP_MUL) || (op == OP_MADD) ||
               (op == OP_MSUB) || (op == OP_DIV);
    endfunction

    function automatic logic op_is_sub(input mdu_op_e op);
        return (op == OP_MSUB) || (op == OP_MSUBU);
    endfunction

    // Clocks from accepting edge to commit edge
    function automatic int unsigned op_latency(input mdu_op_e op, input logic a_neg,
                                               input logic b_neg, input int unsigned w);
        case (op)
            OP_MADD, OP_MADDU, OP_MSUB, OP_MSUBU: return w + 2;
            OP_DIVU:                              return w + 1;
            OP_DIV: begin
                if (b_neg)      return w + 2;
                else if (a_neg) return w + 3;
                else            return w + 1;
            end
            default:                              return w;
        endcase
    endfunction

endpackage

// File: rtl/mdu_mul_engine.sv
module mdu_mul_engine #(
    parameter int unsigned W = 32
) (
    input  logic           clk,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic [2*W-1:0] prod_o
);
    logic [W-1:0]   hi_q, lo_q, mc_q;
    logic [W:0]     sum;
    logic [2*W-1:0] nxt;

    always_comb begin
        sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mc_q} : {(W+1){1'b0}});
        nxt = {sum, lo_q[W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (load) begin
            hi_q <= '0;
            lo_q <= mplier_i;
            mc_q <= mcand_i;
        end else if (step) begin
            {hi_q, lo_q} <= nxt;
        end
    end

    // Value the product holds after this edge
    assign prod_o = step ? nxt : {hi_q, lo_q};
endmodule

// File: rtl/mdu_div_engine.sv
module mdu_div_engine #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    logic [W-1:0] rem_q, quo_q, dsr_q;
    logic [W:0]   shifted;
    logic [W+1:0] diff;
    logic         ge;
    logic [W-1:0] rem_n, quo_n;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        diff    = {1'b0, shifted} - {2'b00, dsr_q};
        ge      = ~diff[W+1];
        rem_n   = ge ? diff[W-1:0] : shifted[W-1:0];
        quo_n   = {quo_q[W-2:0], ge};
    end

    always_ff @(posedge clk) begin
        if (load) begin
            rem_q <= '0;
            quo_q <= dividend_i;
            dsr_q <= divisor_i;
        end else if (step) begin
            rem_q <= rem_n;
            quo_q <= quo_n;
        end
    end

    assign quo_o = step ? quo_n : quo_q;
    assign rem_o = step ? rem_n : rem_q;
endmodule

// File: rtl/mdu_seq.sv
module mdu_seq #(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept_i,
    input  logic [CW-1:0] lat_i,
    output logic          busy_o,
    output logic          step_o,
    output logic          finish_o
);
    localparam int unsigned SW = $clog2(W + 1);

    logic [CW-1:0] cnt_q;
    logic [SW-1:0] steps_q;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            steps_q <= '0;
        end else if (accept_i) begin
            busy_q  <= 1'b1;
            cnt_q   <= lat_i;
            steps_q <= SW'(W);
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
            if (steps_q != '0)
                steps_q <= steps_q - 1'b1;
            if (cnt_q == CW'(1))
                busy_q <= 1'b0;
        end
    end

    assign busy_o   = busy_q;
    assign step_o   = busy_q && (steps_q != '0);
    assign finish_o = busy_q && (cnt_q == CW'(1));
endmodule

// File: rtl/iterative_mdu.sv
module iterative_mdu
    import mdu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         i_start,
    input  logic [3:0]   i_op,
    input  logic [W-1:0] i_a,
    input  logic [W-1:0] i_b,
    input  logic         i_hi_we,
    input  logic [W-1:0] i_hi_wdata,
    input  logic         i_lo_we,
    input  logic [W-1:0] i_lo_wdata,
    output logic         o_busy,
    output logic         o_done,
    output logic [W-1:0] o_gpr,
    output logic [W-1:0] o_hi,
    output logic [W-1:0] o_lo
);
    localparam int unsigned LAT_MAX = W + 3;
    localparam int unsigned CW      = $clog2(LAT_MAX + 1);

    logic           busy, step, finish, accept;
    mdu_op_e        op_in;
    logic           sgn_in, a_neg, b_neg;
    logic [W-1:0]   mag_a, mag_b;
    logic [CW-1:0]  lat;
    mdu_job_t       job_q;

    logic [2*W-1:0] prod, prod_s, hilo, acc;
    logic [W-1:0]   quo, rem, quo_s, rem_s;
    logic [W-1:0]   hi_q, lo_q, gpr_q;
    logic           done_q;

    // Issue-side decode
    always_comb begin
        op_in  = mdu_op_e'(i_op);
        sgn_in = op_signed(op_in);
        a_neg  = sgn_in & i_a[W-1];
        b_neg  = sgn_in & i_b[W-1];
        mag_a  = a_neg ? (~i_a + 1'b1) : i_a;
        mag_b  = b_neg ? (~i_b + 1'b1) : i_b;
        lat    = CW'(op_latency(op_in, a_neg, b_neg, W));
        accept = i_start && !busy && op_legal(i_op);
    end

    always_ff @(posedge clk) begin
        if (rst)
            job_q <= '{op: OP_MULT, neg_main: 1'b0, neg_rem: 1'b0};
        else if (accept)
            job_q <= '{op: op_in, neg_main: a_neg ^ b_neg, neg_rem: a_neg};
    end

    mdu_seq #(.W(W), .CW(CW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .lat_i    (lat),
        .busy_o   (busy),
        .step_o   (step),
        .finish_o (finish)
    );

    mdu_mul_engine #(.W(W)) u_mul (
        .clk      (clk),
        .load     (accept),
        .step     (step),
        .mcand_i  (mag_a),
        .mplier_i (mag_b),
        .prod_o   (prod)
    );

    mdu_div_engine #(.W(W)) u_div (
        .clk        (clk),
        .load       (accept),
        .step       (step),
        .dividend_i (mag_a),
        .divisor_i  (mag_b),
        .quo_o      (quo),
        .rem_o      (rem)
    );

    // Commit-side fix-up and accumulation
    always_comb begin
        prod_s = job_q.neg_main ? (~prod + 1'b1) : prod;
        hilo   = {hi_q, lo_q};
        acc    = op_is_sub(job_q.op) ? (hilo - prod_s) : (hilo + prod_s);
        quo_s  = job_q.neg_main ? (~quo + 1'b1) : quo;
        rem_s  = job_q.neg_rem  ? (~rem + 1'b1) : rem;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            lo_q   <= '0;
            gpr_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) begin
                case (job_q.op)
                    OP_MUL:                               gpr_q <= prod_s[W-1:0];
                    OP_MADD, OP_MADDU, OP_MSUB, OP_MSUBU: {hi_q, lo_q} <= acc;
                    OP_DIV, OP_DIVU: begin
                        lo_q <= quo_s;
                        hi_q <= rem_s;
                    end
                    default:                              {hi_q, lo_q} <= prod_s;
                endcase
            end else if (!busy) begin
                if (i_hi_we) hi_q <= i_hi_wdata;
                if (i_lo_we) lo_q <= i_lo_wdata;
            end
        end
    end

    assign o_busy = busy;
    assign o_done = done_q;
    assign o_gpr  = gpr_q;
    assign o_hi   = hi_q;
    assign o_lo   = lo_q;
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker
    import mdu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         i_start,
    input logic [3:0]   i_op,
    input logic         o_busy,
    input logic         o_done,
    input logic [W-1:0] o_gpr,
    input logic [W-1:0] o_hi,
    input logic [W-1:0] o_lo
);
    localparam int unsigned RW = $clog2(W + 6);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)         run_q <= '0;
        else if (o_busy) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    a_r8_accept: assert property (@(posedge clk) disable iff (rst)
        (i_start && !o_busy && op_legal(i_op)) |=> o_busy);

    a_r10_illegal_ignored: assert property (@(posedge clk) disable iff (rst)
        (i_start && !o_busy && !op_legal(i_op)) |=> !o_busy);

    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        o_done |-> (!o_busy && $past(o_busy)));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        o_done |=> !o_done);

    a_r9_hilo_frozen: assert property (@(posedge clk) disable iff (rst)
        o_busy |=> (o_done || ($stable(o_hi) && $stable(o_lo))));

    a_r11_gpr_hold: assert property (@(posedge clk) disable iff (rst)
        !o_done |-> $stable(o_gpr));

    // R6: no operation stays busy beyond the longest latency
    a_r6_bounded_busy: assert property (@(posedge clk) disable iff (rst)
        o_busy |-> (run_q < RW'(W + 3)));
endmodule

bind iterative_mdu mdu_checker #(.W(W)) u_chk (.*);

// File: tb/iterative_mdu_bench.sv
module iterative_mdu_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         i_start = 1'b0;
    logic [3:0]   i_op = 4'h0;
    logic [W-1:0] i_a = '0, i_b = '0;
    logic         i_hi_we = 1'b0, i_lo_we = 1'b0;
    logic [W-1:0] i_hi_wdata = '0, i_lo_wdata = '0;
    logic         o_busy, o_done;
    logic [W-1:0] o_gpr, o_hi, o_lo;

    int errors = 0;
    int checks = 0;
    int model_gpr = 0;

    always #5 clk = ~clk;

    iterative_mdu #(.W(W)) u_iterative_mdu (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish actual=1 expected=0");
        report();
        $finish;
    end

    function automatic int sx(input int v);
        return (v >= 8) ? v - 16 : v;
    endfunction

    // Expected results from the requirements
    task automatic model(input int op, input int a, input int b, input int hi0, input int lo0,
                         output int ehi, output int elo, output int egpr, output int elat,
                         output string req);
        int sa, sb, p, hl, q, r;
        sa = sx(a); sb = sx(b);
        hl = hi0 * 16 + lo0;
        ehi = hi0; elo = lo0; egpr = model_gpr;
        q = 0; r = 0;
        case (op)
            0: begin p = sa * sb; hl = p & 255; elat = W; req = "R2"; end
            1: begin p = a * b;   hl = p & 255; elat = W; req = "R2"; end
            2: begin egpr = (sa * sb) & 15;     elat = W; req = "R3"; end
            3: begin hl = (hl + sa * sb) & 255; elat = W + 2; req = "R4"; end
            4: begin hl = (hl + a * b) & 255;   elat = W + 2; req = "R4"; end
            5: begin hl = (hl - sa * sb) & 255; elat = W + 2; req = "R4"; end
            6: begin hl = (hl - a * b) & 255;   elat = W + 2; req = "R4"; end
            8: begin
                if (sb != 0) begin q = sa / sb; r = sa % sb; end
                hl = ((r & 15) * 16) + (q & 15);
                if (sb < 0)      elat = W + 2;
                else if (sa < 0) elat = W + 3;
                else             elat = W + 1;
                req = "R6";
            end
            default: begin
                if (b != 0) begin q = a / b; r = a % b; end
                hl = (r * 16) + q;
                elat = W + 1; req = "R5";
            end
        endcase
        if (op != 2) begin ehi = hl / 16; elo = hl % 16; end
    endtask

    task automatic preload(input int hi, input int lo);
        @(negedge clk);
        i_hi_we = 1'b1; i_lo_we = 1'b1;
        i_hi_wdata = W'(hi); i_lo_wdata = W'(lo);
        @(negedge clk);
        i_hi_we = 1'b0; i_lo_we = 1'b0;
    endtask

    // Issue one op and count clocks until done
    task automatic run_op(input int op, input int a, input int b, output int lat);
        @(negedge clk);
        i_start = 1'b1; i_op = 4'(op); i_a = W'(a); i_b = W'(b);
        @(negedge clk);
        i_start = 1'b0;
        lat = 0;
        while (!o_done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        int lat, ehi, elo, egpr, elat, hi0, lo0;
        string req;
        int ops [9] = '{0, 1, 2, 3, 4, 5, 6, 8, 9};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(o_busy == 0 && o_done == 0, "R1", "busy/done after reset", {o_busy, o_done}, 0);
        chk(o_hi == 0 && o_lo == 0 && o_gpr == 0, "R1", "hi/lo/gpr after reset",
            int'({o_hi, o_lo, o_gpr}), 0);

        // R9 idle write
        preload(11, 6);
        chk(o_hi == 11 && o_lo == 6, "R9", "idle HI/LO load", int'({o_hi, o_lo}), 11 * 16 + 6);

        // R10 illegal codes ignored
        for (int c = 10; c <= 16; c++) begin
            int code;
            code = (c == 16) ? 7 : c;
            @(negedge clk);
            i_start = 1'b1; i_op = 4'(code); i_a = 4'd5; i_b = 4'd3;
            @(negedge clk);
            i_start = 1'b0;
            chk(!o_busy, "R10", "busy after illegal op", o_busy, 0);
            chk(o_hi == 11 && o_lo == 6, "R10", "HI/LO after illegal op",
                int'({o_hi, o_lo}), 11 * 16 + 6);
        end

        // Exhaustive sweep: R2 R3 R4 R5 R6 R7 R11
        foreach (ops[k]) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    hi0 = (a * 3 + b) & 15;
                    lo0 = (b * 5 + a + ops[k]) & 15;
                    preload(hi0, lo0);
                    model(ops[k], a, b, hi0, lo0, ehi, elo, egpr, elat, req);
                    run_op(ops[k], a, b, lat);
                    chk(lat == elat, (b == 0 && ops[k] >= 8) ? "R7" : req, "latency", lat, elat);
                    chk(!o_busy, "R8", "busy low at done", o_busy, 0);
                    if (!(ops[k] >= 8 && b == 0))
                        chk(o_hi == ehi && o_lo == elo, req, "HI/LO result",
                            int'({o_hi, o_lo}), ehi * 16 + elo);
                    chk(o_gpr == egpr, (ops[k] == 2) ? "R3" : "R11", "gpr", o_gpr, egpr);
                    model_gpr = egpr;
                end
            end
        end

        // R9 writes ignored while busy: 3*5 unsigned
        @(negedge clk);
        i_start = 1'b1; i_op = 4'd1; i_a = 4'd3; i_b = 4'd5;
        @(negedge clk);
        i_start = 1'b0;
        i_hi_we = 1'b1; i_lo_we = 1'b1; i_hi_wdata = 4'hA; i_lo_wdata = 4'hA;
        @(negedge clk);
        i_hi_we = 1'b0; i_lo_we = 1'b0;
        lat = 1;
        while (!o_done && lat < 60) begin @(negedge clk); lat++; end
        chk(o_hi == 0 && o_lo == 15, "R9", "HI/LO after busy write", int'({o_hi, o_lo}), 15);

        // R8 held request: MULTU 7*9 then DIVU 13/4 queued behind it
        @(negedge clk);
        i_start = 1'b1; i_op = 4'd1; i_a = 4'd7; i_b = 4'd9;
        @(negedge clk);
        i_op = 4'd9; i_a = 4'd13; i_b = 4'd4;
        chk(o_busy, "R8", "busy after accept", o_busy, 1);
        lat = 0;
        while (!o_done && lat < 60) begin @(negedge clk); lat++; end
        chk(lat == W, "R8", "first op latency with held request", lat, W);
        chk(o_hi == 3 && o_lo == 15, "R8", "first result", int'({o_hi, o_lo}), 63);
        @(negedge clk);
        i_start = 1'b0;
        chk(o_busy && !o_done, "R8", "held request accepted next edge", {o_busy, o_done}, 2);
        lat = 0;
        while (!o_done && lat < 60) begin @(negedge clk); lat++; end
        chk(lat == W + 1, "R8", "queued op latency", lat, W + 1);
        chk(o_hi == 1 && o_lo == 3, "R8", "queued DIVU result", int'({o_hi, o_lo}), 19);
        @(negedge clk);
        chk(!o_done, "R8", "done is one cycle", o_done, 0);

        report();
        $finish;
    end
endmodule